// File: doc/BRIEF.md
# Link Transfer Fault Monitor

This block sits between a periodic scan link and the host-side interface. On every scan strobe it receives one data word and one flag that says whether that transfer arrived corrupted. Good words are forwarded to the host. A corrupted transfer does not reach the host: the block keeps presenting the last word that arrived intact. Before any good transfer has arrived, the held word is all zeros.

The block counts unbroken runs of bad scans and unbroken runs of good scans. A run of four bad scans sets a sticky link-fault flag. Only a run of four good scans clears it. While the flag is set, the block holds a reset request to the downstream averaging filters.

The block also has a raw supply-missing input. This input passes through a glitch filter whose length is a parameter counted in clock cycles. The fault output is active low and open-drain. It asks for the pad to be pulled low whenever any of these holds: the sticky link fault, the filtered supply-missing status, or the start-up state in which no good transfer has yet arrived. When none of them holds, the pad is released.

Top module: `lfm_top`

## Requirements
- R1: On a scan strobe with `xfer_err` = 0, `data_out` takes the value of `xfer_data` one clock later.
- R2: On a scan strobe with `xfer_err` = 1, `data_out` keeps its previous value. After reset, `data_out` is 0x00 until the first good scan.
- R3: `filt_rst` goes to 1 on the clock edge that samples the fourth bad scan strobe in a row. A good strobe in between restarts the bad run from zero.
- R4: Once set, `filt_rst` returns to 0 on the edge that samples the fourth good scan strobe in a row. A bad strobe in between restarts the good run from zero.
- R5: Clock cycles with `scan_stb` = 0 are ignored. `xfer_err` and `xfer_data` have no effect on `data_out`, on `filt_rst` or on either run count in those cycles.
- R6: `filt_rst` is 1 exactly while the sticky link-fault flag is set. This reset request goes to the averaging filters.
- R7: `fault_pulldown` is 1 (pad pulled low, error reported) when the link-fault flag, the filtered supply-missing status or the waiting-for-link status is active. Otherwise it is 0 (pad released).
- R8: After reset, the waiting-for-link status is active, so `fault_pulldown` = 1. The first good scan strobe clears this status, and nothing sets it again until the next reset.
- R9: The filtered supply-missing status starts as 1 (missing) at reset. It takes the value of `mv_raw` only after `mv_raw` has differed from it on GLITCH_CYC consecutive clock edges (8000 by default, 40 us at 200 MHz). A shorter excursion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_stb | input | 1 | One-cycle strobe marking a completed scan transfer |
| xfer_err | input | 1 | 1 when the transfer of this scan was corrupted |
| xfer_data | input | 8 | Data word delivered by this scan |
| mv_raw | input | 1 | Unfiltered supply-missing indication, 1 = missing |
| data_out | output | 8 | Last word received without error |
| filt_rst | output | 1 | Reset request to the averaging filters (sticky link fault) |
| fault_pulldown | output | 1 | Open-drain enable: 1 pulls the active-low error pad low |

## Verification
The checker watches the following on every cycle:
- data forwarding on good strobes and data holding on bad ones;
- data and flag stability on cycles without a strobe;
- the rule that a good strobe never sets the sticky flag and a bad strobe never clears it;
- the rule that each fault source forces the pull-down;
- the rule that the waiting status never returns;
- the rule that the filtered supply status only moves toward the raw level.

Some behaviours appear only in the bench scenarios:
- the exact four-in-a-row counts, with interrupted runs that must not trip;
- run counts that carry across idle cycles full of junk;
- the start-up ordering of the waiting and supply faults;
- a supply pulse one cycle too short to pass the filter, against one of exactly the filter length.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
    // Width of the scan data word
    parameter int DATA_W     = 8;
    // Consecutive results needed to set or clear the sticky fault
    parameter int RUN_LEN    = 4;
    // Glitch filter length in clock cycles (40 us at 200 MHz)
    parameter int GLITCH_CYC = 8000;

    // Scan sample carried through the datapath
    typedef struct packed {
        logic              stb;
        logic              bad;
        logic [DATA_W-1:0] word;
    } scan_t;

    // Fault sources combined onto the open-drain pad
    typedef struct packed {
        logic link;
        logic supply;
        logic waiting;
    } fault_src_t;

    function automatic logic any_fault(input fault_src_t f);
        return f.link | f.supply | f.waiting;
    endfunction
endpackage

// File: rtl/lfm_run_counter.sv
module lfm_run_counter #(
    parameter int RUN_LEN = lfm_pkg::RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic match,
    output logic hit
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    // Pulses on the strobe that completes a full run; saturates afterwards
    assign hit = stb & match & (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (stb) begin
            if (!match)
                run_q <= '0;
            else if (run_q != LAST)
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/lfm_glitch_filter.sv
module lfm_glitch_filter #(
    parameter int  GLITCH_CYC = lfm_pkg::GLITCH_CYC,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int GW = $clog2(GLITCH_CYC + 1);
    localparam logic [GW-1:0] LAST = GW'(GLITCH_CYC - 1);

    logic [GW-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level    <= RESET_VAL;
            stable_q <= '0;
        end else if (raw == level) begin
            stable_q <= '0;
        end else if (stable_q == LAST) begin
            level    <= raw;
            stable_q <= '0;
        end else begin
            stable_q <= stable_q + 1'b1;
        end
    end
endmodule

// File: rtl/lfm_data_hold.sv
module lfm_data_hold
    import lfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scan_t             scan,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (scan.stb && !scan.bad)
            held <= scan.word;
    end
endmodule

// File: rtl/lfm_top.sv
module lfm_top
    import lfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_stb,
    input  logic              xfer_err,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              mv_raw,
    output logic [DATA_W-1:0] data_out,
    output logic              filt_rst,
    output logic              fault_pulldown
);
    scan_t      scan;
    fault_src_t src;
    logic       bad_hit;
    logic       good_hit;
    logic       link_q;
    logic       wait_q;
    logic       mv_filt;

    assign scan = '{stb: scan_stb, bad: xfer_err, word: xfer_data};

    lfm_data_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .scan (scan),
        .held (data_out)
    );

    lfm_run_counter #(.RUN_LEN(RUN_LEN)) u_bad_run (
        .clk   (clk),
        .rst   (rst),
        .stb   (scan.stb),
        .match (scan.bad),
        .hit   (bad_hit)
    );

    lfm_run_counter #(.RUN_LEN(RUN_LEN)) u_good_run (
        .clk   (clk),
        .rst   (rst),
        .stb   (scan.stb),
        .match (!scan.bad),
        .hit   (good_hit)
    );

    lfm_glitch_filter #(.GLITCH_CYC(GLITCH_CYC), .RESET_VAL(1'b1)) u_mv_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   (mv_raw),
        .level (mv_filt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= 1'b0;
            wait_q <= 1'b1;
        end else begin
            if (bad_hit)
                link_q <= 1'b1;
            else if (good_hit)
                link_q <= 1'b0;
            if (scan.stb && !scan.bad)
                wait_q <= 1'b0;
        end
    end

    assign src            = '{link: link_q, supply: mv_filt, waiting: wait_q};
    assign filt_rst       = link_q;
    assign fault_pulldown = any_fault(src);
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker
    import lfm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scan_stb,
    input logic              xfer_err,
    input logic [DATA_W-1:0] xfer_data,
    input logic              mv_raw,
    input logic [DATA_W-1:0] data_out,
    input logic              filt_rst,
    input logic              fault_pulldown,
    input logic              wait_q,
    input logic              mv_filt
);
    // R1
    good_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        scan_stb && !xfer_err |=> data_out == $past(xfer_data));
    // R2
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        scan_stb && xfer_err |=> $stable(data_out));
    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_stb |=> $stable(data_out) && $stable(filt_rst));
    // R3
    no_set_on_good_chk: assert property (@(posedge clk) disable iff (rst)
        scan_stb && !xfer_err |=> !$rose(filt_rst));
    // R4
    no_clear_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
        scan_stb && xfer_err |=> !$fell(filt_rst));
    // R6 R7
    link_pulls_chk: assert property (@(posedge clk) disable iff (rst)
        filt_rst |-> fault_pulldown);
    // R7
    supply_pulls_chk: assert property (@(posedge clk) disable iff (rst)
        mv_filt |-> fault_pulldown);
    // R8
    wait_pulls_chk: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> fault_pulldown);
    // R8
    wait_no_return_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(wait_q));
    // R9
    mv_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mv_filt) |-> mv_filt == $past(mv_raw));
endmodule

bind lfm_top lfm_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .scan_stb       (scan_stb),
    .xfer_err       (xfer_err),
    .xfer_data      (xfer_data),
    .mv_raw         (mv_raw),
    .data_out       (data_out),
    .filt_rst       (filt_rst),
    .fault_pulldown (fault_pulldown),
    .wait_q         (wait_q),
    .mv_filt        (mv_filt)
);

// File: tb/lfm_top_bench.sv
module lfm_top_bench;
    import lfm_pkg::*;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              frst;
        logic              fault;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scan_stb = 1'b0;
    logic              xfer_err = 1'b0;
    logic [DATA_W-1:0] xfer_data = '0;
    logic              mv_raw = 1'b1;
    logic [DATA_W-1:0] data_out;
    logic              filt_rst;
    logic              fault_pulldown;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    logic pend = 1'b0;

    // bench model state
    logic [DATA_W-1:0] m_data = '0;
    int   m_bad = 0;
    int   m_good = 0;
    logic m_link = 1'b0;
    logic m_wait = 1'b1;
    logic m_mv = 1'b1;

    always #2.5 clk = ~clk;

    lfm_top u_lfm_top (
        .clk            (clk),
        .rst            (rst),
        .scan_stb       (scan_stb),
        .xfer_err       (xfer_err),
        .xfer_data      (xfer_data),
        .mv_raw         (mv_raw),
        .data_out       (data_out),
        .filt_rst       (filt_rst),
        .fault_pulldown (fault_pulldown)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one strobe, model updated from the requirements, expectation queued
    task automatic scan(input logic bad, input logic [DATA_W-1:0] word, input string tag);
        exp_t e;
        @(negedge clk);
        scan_stb  = 1'b1;
        xfer_err  = bad;
        xfer_data = word;
        if (bad) begin
            m_good = 0;
            m_bad++;
            if (m_bad >= RUN_LEN) m_link = 1'b1;
        end else begin
            m_bad = 0;
            m_good++;
            if (m_good >= RUN_LEN) m_link = 1'b0;
            m_data = word;
            m_wait = 1'b0;
        end
        e.data  = m_data;
        e.frst  = m_link;
        e.fault = m_link | m_mv | m_wait;
        e.tag   = tag;
        exp_q.push_back(e);
        @(negedge clk);
        scan_stb  = 1'b0;
        xfer_err  = 1'b0;
    endtask

    // Monitor: compare one cycle after each sampled strobe
    always @(posedge clk) pend <= scan_stb & ~rst;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " data"},  32'(data_out),       32'(e.data));
            chk({e.tag, " frst"},  32'(filt_rst),       32'(e.frst));
            chk({e.tag, " fault"}, 32'(fault_pulldown), 32'(e.fault));
        end
    end

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst    = 1'b0;
        mv_raw = 1'b0;
        // R8 R2 reset state
        chk("R8 reset fault", 32'(fault_pulldown), 32'd1);
        chk("R2 reset data",  32'(data_out),       32'd0);
        chk("R6 reset frst",  32'(filt_rst),       32'd0);

        // R8 first good clears waiting, supply still filtered as missing (R7)
        scan(1'b0, 8'hA5, "R8 first good");
        repeat (GLITCH_CYC + 4) @(posedge clk);
        m_mv = 1'b0;
        @(negedge clk);
        chk("R9 supply valid releases", 32'(fault_pulldown), 32'd0);

        // R1 / R2 forward and hold
        scan(1'b0, 8'h3C, "R1 good");
        scan(1'b1, 8'h77, "R2 bad holds");
        scan(1'b0, 8'h5A, "R1 good after bad");

        // R3 interrupted bad run must not trip
        for (int i = 0; i < 3; i++) scan(1'b1, 8'hE0, "R3 bad run");
        scan(1'b0, 8'h11, "R3 interrupt");
        for (int i = 0; i < 3; i++) scan(1'b1, 8'hE1, "R3 bad run2");
        scan(1'b1, 8'hE2, "R3 fourth bad sets");

        // R4 interrupted good run must not clear; R1 still forwards
        for (int i = 0; i < 3; i++) scan(1'b0, 8'(8'h20 + i), "R4 good run");
        scan(1'b1, 8'hEE, "R4 interrupt");
        for (int i = 0; i < 3; i++) scan(1'b0, 8'(8'h30 + i), "R4 good run2");
        scan(1'b0, 8'h99, "R4 fourth good clears");

        // R5 idle cycles with junk on the inputs are ignored
        for (int i = 0; i < 3; i++) scan(1'b1, 8'hB0, "R5 bad pre-idle");
        @(negedge clk);
        xfer_err  = 1'b0;
        xfer_data = 8'hFF;
        repeat (5) @(negedge clk);
        xfer_err  = 1'b1;
        xfer_data = 8'h0F;
        repeat (5) @(negedge clk);
        chk("R5 idle data", 32'(data_out), 32'h99);
        chk("R5 idle frst", 32'(filt_rst), 32'd0);
        scan(1'b1, 8'hB1, "R5 run kept over idle");
        for (int i = 0; i < 4; i++) scan(1'b0, 8'h42, "R4 recover");

        // R9 pulse one cycle short of the filter length is ignored
        @(negedge clk);
        mv_raw = 1'b1;
        repeat (GLITCH_CYC - 1) @(posedge clk);
        @(negedge clk);
        mv_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 short pulse ignored", 32'(fault_pulldown), 32'd0);

        // R9 exact-length excursion is accepted on the last edge
        mv_raw = 1'b1;
        repeat (GLITCH_CYC - 1) @(posedge clk);
        @(negedge clk);
        chk("R9 before last edge", 32'(fault_pulldown), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 supply fault pulls", 32'(fault_pulldown), 32'd1);
        chk("R7 link flag clear", 32'(filt_rst), 32'd0);
        mv_raw = 1'b0;
        repeat (GLITCH_CYC + 2) @(negedge clk);
        chk("R9 released again", 32'(fault_pulldown), 32'd0);
        chk("R8 waiting stays clear", 32'(fault_pulldown), 32'd0);

        repeat (3) @(negedge clk);
        chk("queue drained", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule